// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This unit keeps a 64-bit supervisor time-compare value in a control/status register. Every cycle it checks the value against a 64-bit free-running time count and raises a supervisor timer pending flag once the time count has reached the programmed value. The flag feeds the supervisor timer bit of the hart's interrupt-pending register. Prioritising interrupts and entering traps are left to logic outside this unit.

Software reaches the compare register through a CSR port. The unit decides whether each access is legal from three inputs: the current privilege mode, the timer bit of the machine counter-enable register, and a supervisor-compare enable bit from the machine environment-configuration register. On a 32-bit configuration the value is split into two halves at two addresses. On a 64-bit configuration one address covers all 64 bits. Software writes to the pending bit also pass through this unit. Those writes are blocked while hardware owns the bit.

Top module: `sup_timer_cmp`

## Requirements
- R1: The compare register sits at CSR address 0x14D. With XLEN=32 its upper half sits at 0x15D. With XLEN=64 the unit does not claim 0x15D: there is no fault, the read data is 0 and there is no effect.
- R2: When HAS_SMODE or HAS_CMP is 0, every access to a claimed address faults.
- R3: privMode uses the encoding 2'b11 machine, 2'b01 supervisor, 2'b00 user. Machine accesses are always allowed. Supervisor accesses are allowed only when tmEnable and stceEnable are both 1. Every other mode faults.
- R4: A faulting access returns csrRdata of 0 and leaves the compare register unchanged.
- R5: With XLEN=32, address 0x14D reads and writes bits 31..0 and address 0x15D reads and writes bits 63..32. A write to one half leaves the other half as it was.
- R6: With XLEN=64, address 0x14D reads and writes all 64 bits in one access.
- R7: Reset sets the compare register to all ones and clears stiPending.
- R8: When HAS_SMODE and HAS_CMP are both 1, stiPending equals the unsigned result of (compare <= timeIn). It is registered, so it reflects the compare value and timeIn as they stood one cycle earlier.
- R9: When the compare feature is present and stceEnable is 1, a software pending write (stiWe) has no effect on stiPending.
- R10: When the compare feature is present and stceEnable is 0, a software pending write sets stiPending to stiWdata in the next cycle. In the cycle after that the compare result applies again.
- R11: When HAS_SMODE is 1 and HAS_CMP is 0, stiPending is a plain software bit. It takes stiWdata on each stiWe and holds its value otherwise.
- R12: When HAS_SMODE is 0, stiPending stays 0 and software pending writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csrValid | input | 1 | A CSR access is present this cycle |
| csrWe | input | 1 | The access is a write |
| csrAddr | input | 12 | CSR address |
| csrWdata | input | XLEN | CSR write data |
| csrRdata | output | XLEN | CSR read data, combinational |
| csrFault | output | 1 | The access to a claimed address is illegal |
| privMode | input | 2 | Current privilege mode |
| tmEnable | input | 1 | Timer bit of the machine counter-enable register |
| stceEnable | input | 1 | Supervisor-compare enable bit from machine environment configuration |
| stiWe | input | 1 | Software write to the supervisor timer pending bit |
| stiWdata | input | 1 | Value written to the pending bit |
| timeIn | input | 64 | Free-running time count |
| stiPending | output | 1 | Supervisor timer interrupt pending |

## Verification
A corrupted compare register shows up in two places. A machine-mode read returns the wrong half or a stale half in the same cycle. stiPending also flips on the wrong side of the threshold one cycle after timeIn passes the programmed value. To expose these, the bench places compare values just below, at and just above several time values, and it sets values whose only difference is in the upper half or in the top bit, which catches a signed compare. A fault decode that leaks shows as a nonzero csrRdata or a changed register on the very access that is refused. A wrong ownership choice for the pending bit shows as a software write that is visible, or invisible, in the cycle after the write.

// File: rtl/stc_pkg.sv
package stc_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'b00,
    PRIV_SUPER = 2'b01,
    PRIV_RSVD  = 2'b10,
    PRIV_MACH  = 2'b11
  } privT;

  // strobes handed from control to datapath
  typedef struct packed {
    logic rdLo;        // legal access to the low (or only) address
    logic rdHi;        // legal access to the upper-half address
    logic wrLo;
    logic wrHi;
    logic fault;
    logic stiSwTake;   // software value lands in the pending bit
    logic stiHwTrack;  // compare result drives the pending bit
  } ctrlStrobeT;

  localparam int CMP_W = 64;
  localparam logic [11:0] ADDR_CMP_LO = 12'h14D;
  localparam logic [11:0] ADDR_CMP_HI = 12'h15D;

endpackage

// File: rtl/stc_ctrl.sv
module stc_ctrl
  import stc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter bit HAS_SMODE = 1'b1,
  parameter bit HAS_CMP   = 1'b1
) (
  input  logic       csrValid,
  input  logic       csrWe,
  input  logic [11:0] csrAddr,
  input  logic [1:0] privMode,
  input  logic       tmEnable,
  input  logic       stceEnable,
  input  logic       stiWe,
  output ctrlStrobeT strb
);

  localparam bit HI_EXISTS = (XLEN == 32);
  localparam bit DEFINED   = HAS_SMODE && HAS_CMP;

  logic hitLo;
  logic hitHi;
  logic privOk;
  logic legal;

  always_comb begin
    hitLo  = csrValid && (csrAddr == ADDR_CMP_LO);
    hitHi  = HI_EXISTS && csrValid && (csrAddr == ADDR_CMP_HI);
    privOk = (privT'(privMode) == PRIV_MACH) ||
             ((privT'(privMode) == PRIV_SUPER) && tmEnable && stceEnable);
    legal  = DEFINED && privOk;

    strb.fault      = (hitLo || hitHi) && !legal;
    strb.rdLo       = hitLo && legal;
    strb.rdHi       = hitHi && legal;
    strb.wrLo       = hitLo && legal && csrWe;
    strb.wrHi       = hitHi && legal && csrWe;
    strb.stiHwTrack = DEFINED;
    strb.stiSwTake  = HAS_SMODE && stiWe && (!HAS_CMP || !stceEnable);
  end

endmodule

// File: rtl/stc_dp.sv
module stc_dp
  import stc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter bit HAS_SMODE = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strb,
  input  logic [XLEN-1:0]  csrWdata,
  input  logic             stiWdata,
  input  logic [CMP_W-1:0] timeIn,
  output logic [XLEN-1:0]  csrRdata,
  output logic             stiPending,
  output logic [CMP_W-1:0] cmpVal
);

  localparam int HALF_W = CMP_W / 2;

  logic [CMP_W-1:0] cmpReg;
  logic [CMP_W-1:0] cmpNext;

  generate
    if (XLEN == 32) begin : g_split
      always_comb begin
        cmpNext = cmpReg;
        if (strb.wrLo) cmpNext[HALF_W-1:0]     = csrWdata;
        if (strb.wrHi) cmpNext[CMP_W-1:HALF_W] = csrWdata;
      end
      always_comb begin
        if (strb.rdLo)      csrRdata = cmpReg[HALF_W-1:0];
        else if (strb.rdHi) csrRdata = cmpReg[CMP_W-1:HALF_W];
        else                csrRdata = '0;
      end
    end else begin : g_whole
      always_comb begin
        cmpNext = cmpReg;
        if (strb.wrLo) cmpNext = csrWdata;
      end
      assign csrRdata = strb.rdLo ? cmpReg : '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmpReg <= '1;
    else       cmpReg <= cmpNext;
  end

  assign cmpVal = cmpReg;

  generate
    if (HAS_SMODE) begin : g_sti
      logic stiReg;
      logic reached;
      assign reached = (cmpReg <= timeIn);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               stiReg <= 1'b0;
        else if (strb.stiSwTake) stiReg <= stiWdata;
        else if (strb.stiHwTrack) stiReg <= reached;
      end
      assign stiPending = stiReg;
    end else begin : g_nosti
      assign stiPending = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/sup_timer_cmp.sv
module sup_timer_cmp
  import stc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter bit HAS_SMODE = 1'b1,
  parameter bit HAS_CMP   = 1'b1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csrValid,
  input  logic            csrWe,
  input  logic [11:0]     csrAddr,
  input  logic [XLEN-1:0] csrWdata,
  output logic [XLEN-1:0] csrRdata,
  output logic            csrFault,
  input  logic [1:0]      privMode,
  input  logic            tmEnable,
  input  logic            stceEnable,
  input  logic            stiWe,
  input  logic            stiWdata,
  input  logic [63:0]     timeIn,
  output logic            stiPending
);

  ctrlStrobeT strb;
  logic [CMP_W-1:0] cmpVal;

  stc_ctrl #(.XLEN(XLEN), .HAS_SMODE(HAS_SMODE), .HAS_CMP(HAS_CMP)) u_ctrl (
    .csrValid  (csrValid),
    .csrWe     (csrWe),
    .csrAddr   (csrAddr),
    .privMode  (privMode),
    .tmEnable  (tmEnable),
    .stceEnable(stceEnable),
    .stiWe     (stiWe),
    .strb      (strb)
  );

  stc_dp #(.XLEN(XLEN), .HAS_SMODE(HAS_SMODE)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .csrWdata  (csrWdata),
    .stiWdata  (stiWdata),
    .timeIn    (timeIn),
    .csrRdata  (csrRdata),
    .stiPending(stiPending),
    .cmpVal    (cmpVal)
  );

  assign csrFault = strb.fault;

endmodule

// File: rtl/stc_chk.sv
module stc_chk
  import stc_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter bit HAS_SMODE = 1'b1,
  parameter bit HAS_CMP   = 1'b1
) (
  input logic            clk,
  input logic            rstN,
  input logic            csrValid,
  input logic [11:0]     csrAddr,
  input logic [XLEN-1:0] csrRdata,
  input logic            csrFault,
  input logic [1:0]      privMode,
  input logic            stceEnable,
  input logic [63:0]     timeIn,
  input logic            stiPending,
  input logic [63:0]     cmpVal
);

  logic pastOk;
  logic hitAny;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  assign hitAny = csrValid &&
                  ((csrAddr == ADDR_CMP_LO) || ((XLEN == 32) && (csrAddr == ADDR_CMP_HI)));

  AST_UNDEF_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (hitAny && !(HAS_SMODE && HAS_CMP)) |-> csrFault); // R2

  AST_USER_FAULTS: assert property (@(posedge clk) disable iff (!rstN)
    (hitAny && privMode == 2'b00) |-> csrFault); // R3

  AST_FAULT_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    csrFault |-> (csrRdata == '0)); // R4

  AST_FAULT_KEEPS_CMP: assert property (@(posedge clk) disable iff (!rstN)
    csrFault |=> $stable(cmpVal)); // R4

  AST_STI_TRACKS_CMP: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_SMODE && HAS_CMP && pastOk && $past(stceEnable)) |->
      (stiPending == ($past(cmpVal) <= $past(timeIn)))); // R9

endmodule

bind sup_timer_cmp stc_chk #(.XLEN(XLEN), .HAS_SMODE(HAS_SMODE), .HAS_CMP(HAS_CMP)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csrValid  (csrValid),
  .csrAddr   (csrAddr),
  .csrRdata  (csrRdata),
  .csrFault  (csrFault),
  .privMode  (privMode),
  .stceEnable(stceEnable),
  .timeIn    (timeIn),
  .stiPending(stiPending),
  .cmpVal    (cmpVal)
);

// File: tb/sim_sup_timer_cmp.sv
module sim_sup_timer_cmp;

  localparam logic [11:0] A_LO = 12'h14D;
  localparam logic [11:0] A_HI = 12'h15D;
  localparam logic [11:0] A_OTHER = 12'h123;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csrValid = 1'b0;
  logic csrWe = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [63:0] csrWdata = '0;
  logic [1:0] privMode = 2'b11;
  logic tmEnable = 1'b1;
  logic stceEnable = 1'b1;
  logic stiWe = 1'b0;
  logic stiWdata = 1'b0;
  logic [63:0] timeIn = '0;

  logic [31:0] rd0, rd2, rd3;
  logic [63:0] rd1;
  logic f0, f1, f2, f3;
  logic s0, s1, s2, s3;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [63:0] m0 = '1;
  logic [63:0] m1 = '1;

  always #5 clk = ~clk;

  sup_timer_cmp #(.XLEN(32)) u0 (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrWe(csrWe), .csrAddr(csrAddr),
    .csrWdata(csrWdata[31:0]), .csrRdata(rd0), .csrFault(f0), .privMode(privMode),
    .tmEnable(tmEnable), .stceEnable(stceEnable), .stiWe(stiWe), .stiWdata(stiWdata),
    .timeIn(timeIn), .stiPending(s0));

  sup_timer_cmp #(.XLEN(64)) u1 (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrWe(csrWe), .csrAddr(csrAddr),
    .csrWdata(csrWdata), .csrRdata(rd1), .csrFault(f1), .privMode(privMode),
    .tmEnable(tmEnable), .stceEnable(stceEnable), .stiWe(stiWe), .stiWdata(stiWdata),
    .timeIn(timeIn), .stiPending(s1));

  sup_timer_cmp #(.XLEN(32), .HAS_CMP(1'b0)) u2 (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrWe(csrWe), .csrAddr(csrAddr),
    .csrWdata(csrWdata[31:0]), .csrRdata(rd2), .csrFault(f2), .privMode(privMode),
    .tmEnable(tmEnable), .stceEnable(stceEnable), .stiWe(stiWe), .stiWdata(stiWdata),
    .timeIn(timeIn), .stiPending(s2));

  sup_timer_cmp #(.XLEN(32), .HAS_SMODE(1'b0)) u3 (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrWe(csrWe), .csrAddr(csrAddr),
    .csrWdata(csrWdata[31:0]), .csrRdata(rd3), .csrFault(f3), .privMode(privMode),
    .tmEnable(tmEnable), .stceEnable(stceEnable), .stiWe(stiWe), .stiWdata(stiWdata),
    .timeIn(timeIn), .stiPending(s3));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit permOk();
    return (privMode == 2'b11) || (privMode == 2'b01 && tmEnable && stceEnable);
  endfunction

  function automatic bit expF0(input logic [11:0] a);
    return (a == A_LO || a == A_HI) && !permOk();
  endfunction

  function automatic bit expF1(input logic [11:0] a);
    return (a == A_LO) && !permOk();
  endfunction

  function automatic bit expF2(input logic [11:0] a);
    return (a == A_LO || a == A_HI);
  endfunction

  task automatic csrWr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    csrValid = 1'b1; csrWe = 1'b1; csrAddr = a; csrWdata = d;
    if (!expF0(a)) begin
      if (a == A_LO) m0[31:0] = d[31:0];
      if (a == A_HI) m0[63:32] = d[31:0];
    end
    if (!expF1(a) && a == A_LO) m1 = d;
    @(negedge clk);
    csrValid = 1'b0; csrWe = 1'b0;
  endtask

  task automatic csrRdCheck(input logic [11:0] a, input string req);
    logic [31:0] e0;
    logic [63:0] e1;
    @(negedge clk);
    csrValid = 1'b1; csrWe = 1'b0; csrAddr = a;
    #1;
    e0 = '0;
    if (!expF0(a) && a == A_LO) e0 = m0[31:0];
    if (!expF0(a) && a == A_HI) e0 = m0[63:32];
    e1 = (!expF1(a) && a == A_LO) ? m1 : 64'd0;
    check({req, " u0 fault"}, 64'(f0), 64'(expF0(a)));
    check({req, " u0 rdata"}, 64'(rd0), 64'(e0));
    check({req, " u1 fault"}, 64'(f1), 64'(expF1(a)));
    check({req, " u1 rdata"}, rd1, e1);
    check({req, " R2 u2 fault"}, 64'(f2), 64'(expF2(a)));
    check({req, " R2 u3 fault"}, 64'(f3), 64'(expF2(a)));
    check({req, " R4 u2 rdata"}, 64'(rd2), 64'd0);
    @(negedge clk);
    csrValid = 1'b0;
  endtask

  task automatic stiPulse(input logic v);
    @(negedge clk);
    stiWe = 1'b1; stiWdata = v;
    @(negedge clk);
    stiWe = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R7: reset state
    check("R7 u0 sti", 64'(s0), 64'd0);
    check("R7 u1 sti", 64'(s1), 64'd0);
    check("R7 u2 sti", 64'(s2), 64'd0);
    csrRdCheck(A_LO, "R7 low after reset");
    csrRdCheck(A_HI, "R7 high after reset");

    // R1 R3 R2: privilege / enable / address sweep
    for (int p = 0; p < 4; p++)
      for (int tm = 0; tm < 2; tm++)
        for (int st = 0; st < 2; st++)
          for (int ai = 0; ai < 3; ai++) begin
            privMode = 2'(p); tmEnable = tm[0]; stceEnable = st[0];
            csrRdCheck(ai == 0 ? A_LO : (ai == 1 ? A_HI : A_OTHER), "R1 R3 sweep");
          end

    // R5 R6: halves and full-width writes
    privMode = 2'b11; tmEnable = 1'b1; stceEnable = 1'b1;
    csrWr(A_LO, 64'hAAAA_BBBB_1234_5678);
    csrRdCheck(A_LO, "R5 R6 low write");
    csrRdCheck(A_HI, "R5 high kept");
    csrWr(A_HI, 64'h0000_0000_CAFE_F00D);
    csrRdCheck(A_HI, "R5 high write");
    csrRdCheck(A_LO, "R5 low kept");
    csrWr(A_OTHER, 64'h5555);
    csrRdCheck(A_LO, "R1 other address ignored");

    // R4: refused supervisor write leaves state
    privMode = 2'b01; tmEnable = 1'b1; stceEnable = 1'b0;
    csrWr(A_LO, 64'h1111_2222_3333_4444);
    csrWr(A_HI, 64'h0000_0000_9999_9999);
    privMode = 2'b11;
    csrRdCheck(A_LO, "R4 refused low write");
    csrRdCheck(A_HI, "R4 refused high write");
    privMode = 2'b01; stceEnable = 1'b1;
    csrWr(A_LO, 64'h0000_0000_0000_0077);
    csrRdCheck(A_LO, "R3 permitted supervisor write");
    privMode = 2'b11;

    // R8: compare sweep
    csrWr(A_HI, 64'd0);
    for (int c = 0; c < 12; c += 3) begin
      csrWr(A_LO, 64'(c));
      for (int t = 0; t < 13; t++) begin
        @(negedge clk);
        timeIn = 64'(t);
        @(negedge clk);
        check("R8 u0 compare", 64'(s0), 64'(c <= t));
        check("R8 u1 compare", 64'(s1), 64'(c <= t));
      end
    end
    // R8: upper half and unsigned top bit
    csrWr(A_LO, 64'h8000_0000_0000_0000);
    csrWr(A_HI, 64'h0000_0000_8000_0000);
    @(negedge clk); timeIn = 64'd5;
    @(negedge clk);
    check("R8 u0 unsigned top bit", 64'(s0), 64'd0);
    check("R8 u1 unsigned top bit", 64'(s1), 64'd0);
    csrWr(A_HI, 64'd1);
    csrWr(A_LO, 64'h0000_0001_0000_0000);
    @(negedge clk); timeIn = 64'h0000_0000_FFFF_FFFF;
    @(negedge clk);
    check("R8 u0 upper half below", 64'(s0), 64'd0);
    check("R8 u1 upper half below", 64'(s1), 64'd0);
    @(negedge clk); timeIn = 64'h0000_0001_0000_0000;
    @(negedge clk);
    check("R8 u0 upper half equal", 64'(s0), 64'd1);
    check("R8 u1 upper half equal", 64'(s1), 64'd1);

    // R9 R10 R11 R12: software pending writes
    csrWr(A_HI, 64'd0);
    csrWr(A_LO, 64'd1000);
    @(negedge clk); timeIn = 64'd0;
    @(negedge clk);
    stceEnable = 1'b1;
    stiPulse(1'b1);
    check("R9 u0 write ignored", 64'(s0), 64'd0);
    check("R11 u2 write taken", 64'(s2), 64'd1);
    check("R12 u3 stays low", 64'(s3), 64'd0);
    repeat (3) @(negedge clk);
    check("R11 u2 holds", 64'(s2), 64'd1);
    check("R9 u0 still low", 64'(s0), 64'd0);
    stceEnable = 1'b0;
    stiPulse(1'b1);
    check("R10 u0 write taken", 64'(s0), 64'd1);
    check("R12 u3 still low", 64'(s3), 64'd0);
    @(negedge clk);
    check("R10 u0 compare resumes", 64'(s0), 64'd0);
    stiPulse(1'b0);
    check("R11 u2 cleared", 64'(s2), 64'd0);
    @(negedge clk); timeIn = 64'd2000;
    @(negedge clk);
    check("R10 u0 compare with enable low", 64'(s0), 64'd1);
    stiPulse(1'b0);
    check("R10 u0 write zero taken", 64'(s0), 64'd0);
    @(negedge clk);
    check("R10 u0 compare back", 64'(s0), 64'd1);

    finishRun();
  end

endmodule